// File: doc/BRIEF.md
# Security-Banked Private Interrupt Register File

This block is the register file for the 32 interrupts that belong to a single processor. Interrupts 0 to 15 are software-generated. Interrupts 16 to 31 come from per-processor peripheral lines. Software reaches the block through a simple register bus. Each request is one cycle long, may be 8, 32 or 64 bits wide, and carries a secure or non-secure attribute. The block returns the response on the following cycle.

The block holds one bit per interrupt for each of the following: group, group modifier, enable, pending, active and edge/level trigger. It also holds an 8-bit priority per interrupt and a 2-bit non-secure permission field for each software-generated interrupt. A global `sec_disable` input turns off the security banking.

Bitmap accesses made by non-secure software are filtered through the group register. A non-secure access sees each priority in a compressed upper-half form. The pending view seen by software and by the downstream selector merges the latched pending bits with the live level of level-triggered lines. The pending, enable and priority vectors are driven to a downstream selector, which does the arbitration.

Top module: `pirf_top`

## Requirements
- R1: After reset every bitmap, priority, group, modifier, permission and trigger bit is zero, except that the wake register reads 0x6 (sleep request set, children-asleep set).
- R2: A request with `req_valid` is answered one cycle later with `rsp_valid`. The following requests set `bad_access` in that response cycle, return zero data and change no state: an undecoded offset; a size of 1 (16-bit); a byte or 64-bit access outside the priority window 0x40–0x5F; a 32-bit access not 4-byte aligned; a 64-bit access not 8-byte aligned.
- R3: When the access is non-secure and `sec_disable` is 0, 32-bit bitmap reads and writes are masked by the group register (bit = 1 means accessible). Group-0 bits read as zero and ignore writes. In every other case the mask is all ones.
- R4: The pairs set-enable 0x20 / clear-enable 0x24, set-pending 0x28 / clear-pending 0x2C and set-active 0x30 / clear-active 0x34 work as follows. The set register ORs the masked data into the state. The clear register clears the state bits that are 1 in the masked data. Both registers of a pair read back the same masked state.
- R5: Pending reads and `pend_o` equal the pending latch ORed with `ppi_line` for every level-configured interrupt 16–31. A 0-to-1 change of `ppi_line[k]` latches pending bit 16+k only when that interrupt is edge-configured.
- R6: The priority window at 0x40 covers interrupts 0–31, one byte per interrupt. A 32-bit access covers 4 interrupts and a 64-bit access covers 8. The lowest-numbered interrupt sits in the least significant byte.
- R7: When the access is non-secure and `sec_disable` is 0, a priority of a group-0 interrupt reads as zero and ignores writes. A priority of a group-1 interrupt reads as (stored << 1) truncated to 8 bits. A write to it stores 0x80 | (value >> 1).
- R8: The trigger registers are at 0x38 (interrupts 0–15) and 0x3C (interrupts 16–31). Interrupt n's edge bit appears at bit 2·(n mod 16)+1 and is masked as in R3. Software-generated interrupts always read as edge and 0x38 ignores writes. A write to 0x3C takes its odd bits as the new edge bits, under the mask.
- R9: The group register 0x10 reads as zero and ignores writes only for a non-secure access with `sec_disable` 0. The modifier register 0x14 and the permission register 0x18 (bits 2n+1:2n for interrupt n) read as zero and ignore writes unless the access is secure and `sec_disable` is 0.
- R10: A request's group is 0 = Group 0, 1 = Secure Group 1, 2 = Non-secure Group 1. The configured group is Non-secure Group 1 if the group bit is 1. Otherwise it is Secure Group 1 if the modifier bit is 1 and `sec_disable` is 0. Otherwise it is Group 0. A software-generated request sets pending when the two groups match, or when a Secure Group 1 request meets a Group 0 interrupt. All other requests are dropped.
- R11: A non-secure request to a Group 0 or Secure Group 1 interrupt needs a permission field of at least 1 (for Group 0) or at least 2 (for Secure Group 1), unless `sec_disable` is 1.
- R12: In the wake register 0x00 only bit 1 (sleep request) is writable. Bit 2 (children asleep) always reads equal to bit 1. The status register 0x04 reads zero and ignores writes.
- R13: `pend_o`, `enable_o` and `prio_o` (byte n = priority of interrupt n) show the current unmasked state to the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | Global security-disable flag |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half (illegal), 2 word, 3 double word |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 64 | Write data |
| req_secure | input | 1 | Secure access attribute |
| rsp_valid | output | 1 | Response, one cycle after request |
| rsp_rdata | output | 64 | Read data, zero-extended |
| bad_access | output | 1 | One-cycle pulse for a rejected access |
| ppi_line | input | 16 | Levels of peripheral lines for interrupts 16–31 |
| sgi_req | input | 1 | Software-generated interrupt request strobe |
| sgi_id | input | 4 | Target interrupt 0–15 |
| sgi_grp | input | 2 | Requested group (R10 encoding) |
| sgi_ns | input | 1 | Request comes from non-secure software |
| pend_o | output | 32 | Effective pending vector |
| enable_o | output | 32 | Enable vector |
| prio_o | output | 256 | Priority bytes, interrupt n in byte n |

## Verification
A wrong group or mask bit shows up in the cycle after the next non-secure access. In that cycle a bitmap or priority read returns bits that should be zero, or `enable_o`/`prio_o` moves on a bit that should be protected. A broken edge detector or a broken trigger bit shows on `pend_o` at the first clock edge after a line rises, or at once for a level line. An error in the software-interrupt gate shows in the pending vector one cycle after the request strobe. An error in the decoder shows as a wrong `bad_access` or non-zero data on the response cycle.

// File: rtl/pirf_pkg.sv
package pirf_pkg;
    localparam int NUM_IRQ   = 32;
    localparam int NUM_SGI   = 16;
    localparam int NUM_PPI   = NUM_IRQ - NUM_SGI;
    localparam int PRIO_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 64;
    localparam int WORD_W    = 32;
    localparam int LANES     = DATA_W / PRIO_W;
    localparam int IDX_W     = $clog2(NUM_IRQ);
    localparam int SGI_W     = $clog2(NUM_SGI);
    localparam int LANE_CW   = $clog2(LANES) + 1;

    localparam logic [ADDR_W-1:0] OFF_WAKE    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_GROUP   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_GRPMOD  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_NSACC   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_SETEN   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CLREN   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_SETPEND = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_CLRPEND = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_SETACT  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_CLRACT  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_CFGLO   = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_CFGHI   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_PRIO    = 8'h40;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        GRP_0   = 2'd0,
        GRP_1S  = 2'd1,
        GRP_1NS = 2'd2
    } grp_e;

    typedef enum logic [3:0] {
        REG_NONE, REG_WAKE, REG_STATUS, REG_GROUP, REG_GRPMOD, REG_NSACC,
        REG_SETEN, REG_CLREN, REG_SETPEND, REG_CLRPEND, REG_SETACT,
        REG_CLRACT, REG_CFGLO, REG_CFGHI, REG_PRIO
    } reg_e;

    typedef struct packed {
        reg_e               sel;
        logic               bad;
        logic [IDX_W-1:0]   base;
        logic [LANE_CW-1:0] lanes;
    } dec_t;

    // edge bits onto odd positions of a word
    function automatic logic [WORD_W-1:0] spread_odd(input logic [NUM_SGI-1:0] v);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SGI; i++) r[2*i+1] = v[i];
        return r;
    endfunction

    // odd positions of a word back into edge bits
    function automatic logic [NUM_SGI-1:0] gather_odd(input logic [WORD_W-1:0] v);
        logic [NUM_SGI-1:0] r;
        for (int i = 0; i < NUM_SGI; i++) r[i] = v[2*i+1];
        return r;
    endfunction
endpackage

// File: rtl/pirf_decode.sv
module pirf_decode
    import pirf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  size_e             size,
    output dec_t              dec
);
    logic [ADDR_W-1:0] rel;

    always_comb begin
        dec     = '0;
        dec.bad = 1'b1;
        rel     = addr - OFF_PRIO;
        if (addr >= OFF_PRIO && rel < ADDR_W'(NUM_IRQ)) begin
            dec.sel  = REG_PRIO;
            dec.base = rel[IDX_W-1:0];
            case (size)
                SZ_BYTE:  begin dec.lanes = LANE_CW'(1); dec.bad = 1'b0; end
                SZ_WORD:  if (addr[1:0] == 2'b00) begin
                              dec.lanes = LANE_CW'(4); dec.bad = 1'b0;
                          end
                SZ_DWORD: if (addr[2:0] == 3'b000) begin
                              dec.lanes = LANE_CW'(LANES); dec.bad = 1'b0;
                          end
                default:  dec.bad = 1'b1;
            endcase
        end else if (size == SZ_WORD && addr[1:0] == 2'b00) begin
            dec.bad = 1'b0;
            case (addr)
                OFF_WAKE:    dec.sel = REG_WAKE;
                OFF_STATUS:  dec.sel = REG_STATUS;
                OFF_GROUP:   dec.sel = REG_GROUP;
                OFF_GRPMOD:  dec.sel = REG_GRPMOD;
                OFF_NSACC:   dec.sel = REG_NSACC;
                OFF_SETEN:   dec.sel = REG_SETEN;
                OFF_CLREN:   dec.sel = REG_CLREN;
                OFF_SETPEND: dec.sel = REG_SETPEND;
                OFF_CLRPEND: dec.sel = REG_CLRPEND;
                OFF_SETACT:  dec.sel = REG_SETACT;
                OFF_CLRACT:  dec.sel = REG_CLRACT;
                OFF_CFGLO:   dec.sel = REG_CFGLO;
                OFF_CFGHI:   dec.sel = REG_CFGHI;
                default:     dec.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/pirf_prio_bank.sv
module pirf_prio_bank
    import pirf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [IDX_W-1:0]           base,
    input  logic [LANE_CW-1:0]         lanes,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       ns_view,
    input  logic [NUM_IRQ-1:0]         grp,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_IRQ*PRIO_W-1:0]  prio_flat
);
    localparam int LSEL_W = $clog2(LANES);

    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q, prio_d;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        logic [IDX_W-1:0]  off;
        logic [PRIO_W-1:0] wl;
        logic              hit, allow;
        assign off   = IDX_W'(i) - base;
        assign hit   = int'(off) < int'(lanes);
        assign wl    = wdata[off[LSEL_W-1:0]*PRIO_W +: PRIO_W];
        assign allow = !ns_view || grp[i];
        assign prio_d[i] = (wr && hit && allow)
                         ? (ns_view ? {1'b1, wl[PRIO_W-1:1]} : wl)
                         : prio_q[i];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] raw, view;
        assign idx  = base + IDX_W'(k);
        assign raw  = prio_q[idx];
        assign view = !ns_view ? raw : (grp[idx] ? {raw[PRIO_W-2:0], 1'b0} : '0);
        assign rdata[k*PRIO_W +: PRIO_W] = (k < int'(lanes)) ? view : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) prio_q <= '0;
        else     prio_q <= prio_d;
    end

    assign prio_flat = prio_q;
endmodule

// File: rtl/pirf_sgi_gate.sv
module pirf_sgi_gate
    import pirf_pkg::*;
(
    input  logic               req,
    input  logic [SGI_W-1:0]   id,
    input  grp_e               req_grp,
    input  logic               req_ns,
    input  logic               ds,
    input  logic [NUM_SGI-1:0] grp,
    input  logic [NUM_SGI-1:0] mod,
    input  logic [2*NUM_SGI-1:0] nsacc,
    output logic [NUM_SGI-1:0] set
);
    grp_e       cfg;
    logic [1:0] field;
    logic       match, ns_ok;

    always_comb begin
        if (grp[id])              cfg = GRP_1NS;
        else if (mod[id] && !ds)  cfg = GRP_1S;
        else                      cfg = GRP_0;
        field = nsacc[{id, 1'b0} +: 2];
        match = (req_grp == cfg) || (req_grp == GRP_1S && cfg == GRP_0);
        ns_ok = !req_ns || ds || (cfg == GRP_1NS) ||
                ((cfg == GRP_0) ? (field >= 2'd1) : (field >= 2'd2));
        set = '0;
        if (req && match && ns_ok) set[id] = 1'b1;
    end
endmodule

// File: rtl/pirf_top.sv
module pirf_top
    import pirf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sec_disable,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic                      req_secure,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      bad_access,
    input  logic [NUM_PPI-1:0]        ppi_line,
    input  logic                      sgi_req,
    input  logic [SGI_W-1:0]          sgi_id,
    input  logic [1:0]                sgi_grp,
    input  logic                      sgi_ns,
    output logic [NUM_IRQ-1:0]        pend_o,
    output logic [NUM_IRQ-1:0]        enable_o,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_o
);
    dec_t dec;
    logic [NUM_IRQ-1:0]   grp_q, mod_q, en_q, pend_q, act_q;
    logic [NUM_IRQ-1:0]   grp_d, mod_d, en_d, pend_d, act_d;
    logic [2*NUM_SGI-1:0] nsacc_q, nsacc_d;
    logic [NUM_PPI-1:0]   edge_hi_q, edge_hi_d, line_q;
    logic                 sleep_q, sleep_d;
    logic [NUM_SGI-1:0]   sgi_set;
    logic [DATA_W-1:0]    prio_rd, rd64;
    logic [WORD_W-1:0]    bmask, wdw, rd_word;
    logic [NUM_IRQ-1:0]   edge_full, pend_view;
    logic ns_lim, sec_only, do_wr;

    pirf_decode u_dec (.addr(req_addr), .size(size_e'(req_size)), .dec(dec));

    assign ns_lim    = !req_secure && !sec_disable;
    assign sec_only  = req_secure && !sec_disable;
    assign bmask     = ns_lim ? grp_q : '1;
    assign wdw       = req_wdata[WORD_W-1:0] & bmask;
    assign do_wr     = req_valid && req_write && !dec.bad;
    assign edge_full = {edge_hi_q, {NUM_SGI{1'b1}}};
    assign pend_view = pend_q | (~edge_full & {ppi_line, {NUM_SGI{1'b0}}});

    pirf_prio_bank u_prio (
        .clk(clk), .rst(rst), .wr(do_wr && dec.sel == REG_PRIO),
        .base(dec.base), .lanes(dec.lanes), .wdata(req_wdata),
        .ns_view(ns_lim), .grp(grp_q), .rdata(prio_rd), .prio_flat(prio_o));

    pirf_sgi_gate u_sgi (
        .req(sgi_req), .id(sgi_id), .req_grp(grp_e'(sgi_grp)), .req_ns(sgi_ns),
        .ds(sec_disable), .grp(grp_q[NUM_SGI-1:0]), .mod(mod_q[NUM_SGI-1:0]),
        .nsacc(nsacc_q), .set(sgi_set));

    // next state
    always_comb begin
        grp_d = grp_q; mod_d = mod_q; nsacc_d = nsacc_q;
        en_d = en_q; pend_d = pend_q; act_d = act_q;
        edge_hi_d = edge_hi_q; sleep_d = sleep_q;
        if (do_wr) begin
            case (dec.sel)
                REG_WAKE:    sleep_d = req_wdata[1];
                REG_GROUP:   if (!ns_lim) grp_d = req_wdata[WORD_W-1:0];
                REG_GRPMOD:  if (sec_only) mod_d = req_wdata[WORD_W-1:0];
                REG_NSACC:   if (sec_only) nsacc_d = req_wdata[2*NUM_SGI-1:0];
                REG_SETEN:   en_d   = en_q | wdw;
                REG_CLREN:   en_d   = en_q & ~wdw;
                REG_SETPEND: pend_d = pend_q | wdw;
                REG_CLRPEND: pend_d = pend_q & ~wdw;
                REG_SETACT:  act_d  = act_q | wdw;
                REG_CLRACT:  act_d  = act_q & ~wdw;
                REG_CFGHI:   edge_hi_d = (edge_hi_q & ~bmask[WORD_W-1:NUM_SGI]) |
                                 (gather_odd(req_wdata[WORD_W-1:0]) & bmask[WORD_W-1:NUM_SGI]);
                default: ;
            endcase
        end
        pend_d = pend_d | {ppi_line & ~line_q & edge_hi_q, sgi_set};
    end

    // read mux
    always_comb begin
        case (dec.sel)
            REG_WAKE:    rd_word = {29'd0, sleep_q, sleep_q, 1'b0};
            REG_GROUP:   rd_word = ns_lim ? '0 : grp_q;
            REG_GRPMOD:  rd_word = sec_only ? mod_q : '0;
            REG_NSACC:   rd_word = sec_only ? nsacc_q : '0;
            REG_SETEN, REG_CLREN:     rd_word = en_q & bmask;
            REG_SETPEND, REG_CLRPEND: rd_word = pend_view & bmask;
            REG_SETACT, REG_CLRACT:   rd_word = act_q & bmask;
            REG_CFGLO:   rd_word = spread_odd(edge_full[NUM_SGI-1:0] & bmask[NUM_SGI-1:0]);
            REG_CFGHI:   rd_word = spread_odd(edge_full[NUM_IRQ-1:NUM_SGI] & bmask[WORD_W-1:NUM_SGI]);
            default:     rd_word = '0;
        endcase
        rd64 = (dec.sel == REG_PRIO) ? prio_rd : {{(DATA_W-WORD_W){1'b0}}, rd_word};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0; mod_q <= '0; nsacc_q <= '0;
            en_q <= '0; pend_q <= '0; act_q <= '0;
            edge_hi_q <= '0; line_q <= '0; sleep_q <= 1'b1;
            rsp_valid <= 1'b0; rsp_rdata <= '0; bad_access <= 1'b0;
        end else begin
            grp_q <= grp_d; mod_q <= mod_d; nsacc_q <= nsacc_d;
            en_q <= en_d; pend_q <= pend_d; act_q <= act_d;
            edge_hi_q <= edge_hi_d; line_q <= ppi_line; sleep_q <= sleep_d;
            rsp_valid  <= req_valid;
            rsp_rdata  <= (req_valid && !req_write && !dec.bad) ? rd64 : '0;
            bad_access <= req_valid && dec.bad;
        end
    end

    assign pend_o   = pend_view;
    assign enable_o = en_q;
endmodule

// File: rtl/pirf_sva.sv
module pirf_sva
    import pirf_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      sec_disable,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [1:0]                req_size,
    input logic [ADDR_W-1:0]         req_addr,
    input logic                      req_secure,
    input logic                      rsp_valid,
    input logic [DATA_W-1:0]         rsp_rdata,
    input logic                      bad_access,
    input logic [NUM_PPI-1:0]        ppi_line,
    input logic [NUM_IRQ-1:0]        pend_o,
    input logic [NUM_IRQ-1:0]        enable_o,
    input logic [NUM_IRQ*PRIO_W-1:0] prio_o,
    input logic [NUM_IRQ-1:0]        grp_q,
    input logic [NUM_PPI-1:0]        edge_hi_q
);
    logic ns_wr;
    assign ns_wr = req_valid && req_write && !req_secure && !sec_disable;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_bad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> (rsp_valid && rsp_rdata == '0));

    assert_ns_mask_R3: assert property (@(posedge clk) disable iff (rst)
        ns_wr |=> ((enable_o & ~$past(grp_q)) == ($past(enable_o) & ~$past(grp_q))));

    assert_level_view_R5: assert property (@(posedge clk) disable iff (rst)
        ((ppi_line & ~edge_hi_q & ~pend_o[NUM_IRQ-1:NUM_SGI]) == '0));

    assert_ns_prio_msb_R7: assert property (@(posedge clk) disable iff (rst)
        (ns_wr && req_size == 2'd0 && req_addr >= OFF_PRIO &&
         req_addr < OFF_PRIO + ADDR_W'(NUM_IRQ) && grp_q[req_addr[IDX_W-1:0]])
        |=> prio_o[{$past(req_addr[IDX_W-1:0]), 3'd7}]);
endmodule

bind pirf_top pirf_sva u_sva (.*);

// File: tb/pirf_top_tb.sv
`timescale 1ns/1ps
module pirf_top_tb;
    logic clk = 1'b0, rst = 1'b1, sec_disable = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [1:0] req_size = 2'd0;
    logic [7:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, bad_access;
    logic [63:0] rsp_rdata;
    logic [15:0] ppi_line = '0;
    logic sgi_req = 1'b0, sgi_ns = 1'b0;
    logic [3:0] sgi_id = '0;
    logic [1:0] sgi_grp = '0;
    logic [31:0] pend_o, enable_o;
    logic [255:0] prio_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    localparam logic [7:0] A_WAKE = 8'h00, A_STAT = 8'h04, A_GRP = 8'h10, A_MOD = 8'h14,
        A_NSA = 8'h18, A_SEN = 8'h20, A_CEN = 8'h24, A_SPD = 8'h28, A_CPD = 8'h2C,
        A_SAC = 8'h30, A_CAC = 8'h34, A_CLO = 8'h38, A_CHI = 8'h3C, A_PRI = 8'h40;

    always #2 clk = ~clk;

    pirf_top u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                       input logic [63:0] d, input logic sec,
                       output logic [63:0] rd, output logic bd);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = d; req_secure = sec;
        @(posedge clk); @(negedge clk);
        rd = rsp_rdata; bd = bad_access;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d, input logic sec);
        logic [63:0] r; logic b;
        bus(1'b1, 2'd2, a, {32'd0, d}, sec, r, b);
    endtask

    task automatic rd32(input logic [7:0] a, input logic sec, output logic [63:0] r);
        logic b;
        bus(1'b0, 2'd2, a, '0, sec, r, b);
    endtask

    task automatic sgi(input logic [3:0] id, input logic [1:0] g, input logic ns);
        sgi_req = 1'b1; sgi_id = id; sgi_grp = g; sgi_ns = ns;
        @(posedge clk); @(negedge clk);
        sgi_req = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] r;
        rd32(A_WAKE, 1'b1, r); chk("R1 R12 wake reset", r, 64'h6);
        chk("R1 enable reset", {32'd0, enable_o}, 64'h0);
        chk("R1 pend reset", {32'd0, pend_o}, 64'h0);
        chk("R1 prio reset", {63'd0, |prio_o}, 64'h0);
    endtask

    task automatic t_setclr;
        logic [63:0] r;
        wr32(A_SEN, 32'h0000_F00F, 1'b1);
        rd32(A_CEN, 1'b1, r); chk("R4 clear-enable reads state", r, 64'hF00F);
        wr32(A_CEN, 32'h3, 1'b1);
        rd32(A_SEN, 1'b1, r); chk("R4 clear-enable clears", r, 64'hF00C);
        chk("R13 enable_o", {32'd0, enable_o}, 64'hF00C);
        wr32(A_SAC, 32'h00FF_0000, 1'b1);
        wr32(A_CAC, 32'h000F_0000, 1'b1);
        rd32(A_SAC, 1'b1, r); chk("R4 active pair", r, 64'h00F0_0000);
    endtask

    task automatic t_nsmask;
        logic [63:0] r;
        wr32(A_GRP, 32'h0000_FF00, 1'b1);
        wr32(A_SEN, 32'hFFFF_FFFF, 1'b0);
        chk("R3 ns set-enable masked", {32'd0, enable_o}, 64'hFF0C);
        rd32(A_SEN, 1'b0, r); chk("R3 ns read masked", r, 64'hFF00);
        rd32(A_GRP, 1'b0, r); chk("R9 ns group raz", r, 64'h0);
        wr32(A_GRP, 32'h0, 1'b0);
        rd32(A_GRP, 1'b1, r); chk("R9 ns group wi", r, 64'hFF00);
    endtask

    task automatic t_prio;
        logic [63:0] r; logic b;
        wr32(A_PRI + 8'd8, 32'h4433_2211, 1'b1);
        bus(1'b0, 2'd0, A_PRI + 8'd9, '0, 1'b1, r, b); chk("R6 byte read", r, 64'h22);
        bus(1'b0, 2'd3, A_PRI + 8'd8, '0, 1'b1, r, b); chk("R6 dword read", r, 64'h4433_2211);
        chk("R13 prio_o byte 9", {56'd0, prio_o[9*8 +: 8]}, 64'h22);
        bus(1'b0, 2'd0, A_PRI + 8'd8, '0, 1'b0, r, b); chk("R7 ns view shift", r, 64'h22);
        bus(1'b1, 2'd0, A_PRI, 64'h55, 1'b1, r, b);
        bus(1'b0, 2'd0, A_PRI, '0, 1'b0, r, b); chk("R7 ns group0 raz", r, 64'h0);
        bus(1'b1, 2'd0, A_PRI + 8'd10, 64'h40, 1'b0, r, b);
        bus(1'b0, 2'd0, A_PRI + 8'd10, '0, 1'b1, r, b); chk("R7 ns write compress", r, 64'hA0);
        bus(1'b1, 2'd0, A_PRI, 64'h77, 1'b0, r, b);
        bus(1'b0, 2'd0, A_PRI, '0, 1'b1, r, b); chk("R7 ns group0 wi", r, 64'h55);
        sec_disable = 1'b1;
        bus(1'b0, 2'd0, A_PRI + 8'd8, '0, 1'b0, r, b); chk("R7 ds raw view", r, 64'h11);
        sec_disable = 1'b0;
    endtask

    task automatic t_cfg;
        logic [63:0] r;
        wr32(A_CHI, 32'h0000_0200, 1'b1);
        rd32(A_CHI, 1'b1, r); chk("R8 cfg hi readback", r, 64'h200);
        rd32(A_CLO, 1'b1, r); chk("R8 cfg lo edges", r, 64'hAAAA_AAAA);
        wr32(A_CLO, 32'h0, 1'b1);
        rd32(A_CLO, 1'b1, r); chk("R8 cfg lo wi", r, 64'hAAAA_AAAA);
        rd32(A_CLO, 1'b0, r); chk("R8 cfg lo ns masked", r, 64'hAAAA_0000);
        wr32(A_CHI, 32'hFFFF_FFFF, 1'b0);
        rd32(A_CHI, 1'b1, r); chk("R8 cfg hi ns masked write", r, 64'h200);
    endtask

    task automatic t_pend;
        logic [63:0] r;
        ppi_line[1] = 1'b1; #1;
        chk("R5 level pend live", {63'd0, pend_o[17]}, 64'h1);
        rd32(A_SPD, 1'b1, r); chk("R5 level pend read", r, 64'h0002_0000);
        ppi_line[1] = 1'b0; #1;
        chk("R5 level drop", {63'd0, pend_o[17]}, 64'h0);
        @(negedge clk);
        ppi_line[4] = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 edge latch", {63'd0, pend_o[20]}, 64'h1);
        ppi_line[4] = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R5 edge held", {63'd0, pend_o[20]}, 64'h1);
        wr32(A_CPD, 32'h0010_0000, 1'b1);
        chk("R4 clear pending", {63'd0, pend_o[20]}, 64'h0);
        ppi_line[5] = 1'b1;
        @(posedge clk); @(negedge clk);
        ppi_line[5] = 1'b0; #1;
        chk("R5 level no latch", {63'd0, pend_o[21]}, 64'h0);
        @(negedge clk);
        wr32(A_SPD, 32'h1, 1'b1);
        rd32(A_CPD, 1'b1, r); chk("R4 pend pair read", r, 64'h1);
        wr32(A_CPD, 32'h1, 1'b1);
    endtask

    task automatic t_sgi;
        logic [63:0] r;
        wr32(A_MOD, 32'h2, 1'b1);
        rd32(A_MOD, 1'b0, r); chk("R9 ns grpmod raz", r, 64'h0);
        sgi(4'd0, 2'd0, 1'b0); chk("R10 G0 match", {63'd0, pend_o[0]}, 64'h1);
        sgi(4'd2, 2'd1, 1'b0); chk("R10 G1S to G0", {63'd0, pend_o[2]}, 64'h1);
        sgi(4'd3, 2'd2, 1'b0); chk("R10 G1NS to G0 dropped", {63'd0, pend_o[3]}, 64'h0);
        sgi(4'd1, 2'd0, 1'b0); chk("R10 G0 to G1S dropped", {63'd0, pend_o[1]}, 64'h0);
        sgi(4'd1, 2'd1, 1'b0); chk("R10 G1S match", {63'd0, pend_o[1]}, 64'h1);
        wr32(A_CPD, 32'h0000_FFFF, 1'b1);
        sgi(4'd4, 2'd0, 1'b1); chk("R11 ns no permission", {63'd0, pend_o[4]}, 64'h0);
        wr32(A_NSA, 32'h0000_0104, 1'b1);
        sgi(4'd4, 2'd0, 1'b1); chk("R11 ns G0 permitted", {63'd0, pend_o[4]}, 64'h1);
        sgi(4'd1, 2'd1, 1'b1); chk("R11 ns G1S needs 2", {63'd0, pend_o[1]}, 64'h0);
        sgi(4'd9, 2'd2, 1'b1); chk("R11 ns G1NS free", {63'd0, pend_o[9]}, 64'h1);
        rd32(A_NSA, 1'b0, r); chk("R9 ns nsacc raz", r, 64'h0);
        rd32(A_NSA, 1'b1, r); chk("R9 nsacc secure read", r, 64'h104);
        sec_disable = 1'b1;
        rd32(A_GRP, 1'b0, r); chk("R9 ds group open", r, 64'hFF00);
        rd32(A_MOD, 1'b1, r); chk("R9 ds grpmod raz", r, 64'h0);
        sec_disable = 1'b0;
    endtask

    task automatic t_bad;
        logic [63:0] r; logic b;
        bus(1'b0, 2'd2, 8'h60, '0, 1'b1, r, b);
        chk("R2 undecoded bad", {63'd0, b}, 64'h1); chk("R2 undecoded data", r, 64'h0);
        bus(1'b0, 2'd0, A_WAKE, '0, 1'b1, r, b); chk("R2 byte non-prio bad", {63'd0, b}, 64'h1);
        bus(1'b0, 2'd2, A_PRI + 8'd2, '0, 1'b1, r, b); chk("R2 misaligned word", {63'd0, b}, 64'h1);
        bus(1'b0, 2'd3, A_PRI + 8'd4, '0, 1'b1, r, b); chk("R2 misaligned dword", {63'd0, b}, 64'h1);
        bus(1'b0, 2'd1, A_PRI, '0, 1'b1, r, b); chk("R2 half size", {63'd0, b}, 64'h1);
        bus(1'b1, 2'd3, A_SEN, 64'hFFFF_FFFF, 1'b1, r, b);
        chk("R2 dword non-prio bad", {63'd0, b}, 64'h1);
        chk("R2 bad write no effect", {32'd0, enable_o}, 64'hFF0C);
        bus(1'b0, 2'd2, A_SEN, '0, 1'b1, r, b); chk("R2 good access", {63'd0, b}, 64'h0);
    endtask

    task automatic t_wake;
        logic [63:0] r;
        wr32(A_WAKE, 32'h0, 1'b1);
        rd32(A_WAKE, 1'b1, r); chk("R12 wake cleared", r, 64'h0);
        wr32(A_WAKE, 32'hFFFF_FFFF, 1'b1);
        rd32(A_WAKE, 1'b1, r); chk("R12 wake only sleep bit", r, 64'h6);
        wr32(A_STAT, 32'hFFFF_FFFF, 1'b1);
        rd32(A_STAT, 1'b1, r); chk("R12 status raz", r, 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset(); t_setclr(); t_nsmask(); t_prio(); t_cfg();
        t_pend(); t_sgi(); t_bad(); t_wake();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule